// File: doc/BRIEF.md
# Calibrated Seconds Strobe Divider

This block turns a slow oscillator tick enable into a one-cycle seconds strobe. The number of oscillator ticks that make up one second comes from a packed calibration word. That word holds an integer tick count, a small fractional trim value and a bit that switches the trim on. When the trim is on, some seconds are stretched by one extra tick. These seconds are spread evenly by a modulo-16 accumulator, so that crystal drift can be trimmed over the long term.

Writing the calibration word restarts the division. The partial second in progress is dropped, and the next strobe comes exactly one programmed period after the write. The block also reports how many ticks have passed in the current second.

Inside, a two-state machine does the division. In CNT_BASE it counts the integer part of the period. On the last base tick it does one of two things. If the second needs no extra tick, it wraps to zero and stays in CNT_BASE (transition BASE_WRAP). If the second needs an extra tick, it moves to CNT_TRIM (transition BASE_TO_TRIM). In CNT_TRIM the next tick ends the second and the machine returns to CNT_BASE (transition TRIM_WRAP). A calibration write forces CNT_BASE from either state (transition RESTART).

Top module: `second_tick_divider`

## Requirements
- R1: Reset loads the calibration word 0x198233. That is an integer count of 0x8233 (33331), a trim value of 9, and the trim enabled. Reset also clears the tick count and the trim accumulator and holds the strobe low. With the tick enable held high, the first strobe follows the 33331st tick.
- R2: The tick count advances only on cycles where the tick enable is high, and holds on all other cycles. It always equals the number of ticks taken in the current second.
- R3: The integer count sits in word bits [15:0]. With no extra tick, a second lasts that many ticks. The strobe is high for the one cycle after the edge that samples the last tick of the second, and the tick count is 0 in that same cycle. A count of 0 or 1 gives a one-tick base period.
- R4: The trim value sits in bits [19:16] and the enable sits in bit 20. The 4-bit accumulator starts at 0. While the trim is enabled, a second takes one extra tick (through CNT_TRIM) exactly when accumulator + trim ≥ 16. At the end of each second the accumulator becomes (accumulator + trim) mod 16. This gives the extra tick in trim seconds out of every 16.
- R5: With bit 20 clear, no second ever takes an extra tick, whatever the trim field holds.
- R6: A calibration write clears the tick count and the accumulator and returns the machine to CNT_BASE. The write produces no strobe, and the next strobe comes one full period of the new word later.
- R7: When a write and a tick arrive in the same cycle, the write takes effect and that tick is not counted.
- R8: Input bits above bit 20 of the calibration data are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick_i | input | 1 | Oscillator tick enable, one cycle per oscillator tick |
| cal_wr_i | input | 1 | Calibration write strobe |
| cal_data_i | input | 32 | Calibration data; only bits [20:0] are used |
| sec_pulse_o | output | 1 | One-cycle seconds strobe |
| tick_cnt_o | output | 16 | Ticks taken in the current second |

## Verification
The bench builds the block with its default parameters: a 16-bit integer count, a 4-bit trim field and a 32-bit data input. Because of this, the reset calibration of 33331 ticks is checked through one full second, and upper-bit masking can be driven on the real input width. Small programmed counts bring a whole 16-second trim cycle and the counts of 0 and 1 within a few hundred cycles. The bench drives ticks both back-to-back and with gaps between them, and it places writes in the middle of a second and in the same cycle as a tick.

// File: rtl/calsec_pkg.sv
package calsec_pkg;

    // Division machine states
    typedef enum logic [0:0] {
        CNT_BASE = 1'b0,
        CNT_TRIM = 1'b1
    } cnt_state_e;

endpackage

// File: rtl/cal_word_reg.sv
module cal_word_reg #(
    parameter int CNT_W  = 16,
    parameter int FRAC_W = 4,
    parameter int BUS_W  = 32,
    parameter logic [CNT_W+FRAC_W:0] CAL_DEFAULT = 21'h198233
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [BUS_W-1:0]  data_i,
    output logic [CNT_W-1:0]  lim_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic              fen_o
);
    localparam int CAL_W  = CNT_W + FRAC_W + 1;
    localparam int FEN_B  = CNT_W + FRAC_W;

    logic [CAL_W-1:0] cal_q;

    generate
        if (BUS_W > CAL_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^data_i[BUS_W-1:CAL_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)
            cal_q <= CAL_DEFAULT;
        else if (wr_i)
            cal_q <= data_i[CAL_W-1:0];
    end

    assign lim_o  = cal_q[CNT_W-1:0];
    assign frac_o = cal_q[FEN_B-1:CNT_W];
    assign fen_o  = cal_q[FEN_B];

    // R8
    cal_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (cal_q == $past(data_i[CAL_W-1:0])));

endmodule

// File: rtl/trim_accum.sv
module trim_accum #(
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              adv_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              fen_i,
    output logic              extra_o
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    assign sum     = {1'b0, acc_q} + {1'b0, frac_i};
    assign extra_o = fen_i & sum[FRAC_W];

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            acc_q <= '0;
        else if (adv_i && fen_i)
            acc_q <= sum[FRAC_W-1:0];
    end

    // R5
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fen_i && !clr_i) |=> $stable(acc_q));

    // R6
    acc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_q == '0));

endmodule

// File: rtl/tick_div_fsm.sv
module tick_div_fsm
    import calsec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] lim_i,
    input  logic             extra_i,
    output logic             sec_adv_o,
    output logic             sec_pulse_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W-1:0] lim_eff;
    logic             base_done;
    logic             wrap;
    logic             pulse_q;

    assign lim_eff   = (lim_i == '0) ? ONE : lim_i;
    assign cnt_inc   = {1'b0, cnt_q} + {1'b0, ONE};
    assign base_done = (cnt_inc >= {1'b0, lim_eff});

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        wrap    = 1'b0;
        if (restart_i) begin
            state_d = CNT_BASE;
            cnt_d   = '0;
        end else if (tick_i) begin
            unique case (state_q)
                CNT_BASE: begin
                    if (base_done && extra_i) begin
                        state_d = CNT_TRIM;
                        cnt_d   = cnt_inc[CNT_W-1:0];
                    end else if (base_done) begin
                        wrap  = 1'b1;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_inc[CNT_W-1:0];
                    end
                end
                CNT_TRIM: begin
                    wrap    = 1'b1;
                    cnt_d   = '0;
                    state_d = CNT_BASE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_BASE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else
            pulse_q <= wrap;
    end

    assign sec_adv_o   = wrap;
    assign sec_pulse_o = pulse_q;
    assign cnt_o       = cnt_q;

    // R3
    pulse_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (cnt_q == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i) |=> ($stable(cnt_q) && !pulse_q));

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0 && !pulse_q && state_q == CNT_BASE));

    // R3
    base_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_BASE) |-> (cnt_q < lim_eff));

    // R4
    trim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_TRIM && tick_i && !restart_i) |=> pulse_q);

endmodule

// File: rtl/second_tick_divider.sv
module second_tick_divider #(
    parameter int CNT_W  = 16,
    parameter int FRAC_W = 4,
    parameter int BUS_W  = 32,
    parameter logic [CNT_W+FRAC_W:0] CAL_DEFAULT = 21'h198233
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick_i,
    input  logic             cal_wr_i,
    input  logic [BUS_W-1:0] cal_data_i,
    output logic             sec_pulse_o,
    output logic [CNT_W-1:0] tick_cnt_o
);
    logic [CNT_W-1:0]  lim;
    logic [FRAC_W-1:0] frac;
    logic              fen;
    logic              extra;
    logic              sec_adv;

    cal_word_reg #(
        .CNT_W(CNT_W), .FRAC_W(FRAC_W), .BUS_W(BUS_W), .CAL_DEFAULT(CAL_DEFAULT)
    ) u_cal (
        .clk(clk), .rst_n(rst_n), .wr_i(cal_wr_i), .data_i(cal_data_i),
        .lim_o(lim), .frac_o(frac), .fen_o(fen)
    );

    trim_accum #(.FRAC_W(FRAC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr_i(cal_wr_i), .adv_i(sec_adv),
        .frac_i(frac), .fen_i(fen), .extra_o(extra)
    );

    tick_div_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_i(osc_tick_i), .restart_i(cal_wr_i),
        .lim_i(lim), .extra_i(extra), .sec_adv_o(sec_adv),
        .sec_pulse_o(sec_pulse_o), .cnt_o(tick_cnt_o)
    );

endmodule

// File: tb/second_tick_divider_bench.sv
module second_tick_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b0;
    logic        cal_wr = 1'b0;
    logic [31:0] cal_data = '0;
    logic        sec_pulse;
    logic [15:0] tick_cnt;

    int unsigned edge_cnt = 0;
    int unsigned exp_q[$];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_n = 32'h8233, m_f = 9, m_fen = 1, m_acc = 0, m_pos = 0;

    second_tick_divider u_second_tick_divider (
        .clk(clk), .rst_n(rst_n), .osc_tick_i(osc_tick), .cal_wr_i(cal_wr),
        .cal_data_i(cal_data), .sec_pulse_o(sec_pulse), .tick_cnt_o(tick_cnt)
    );

    always #5 clk = ~clk;
    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    // Monitor: pop expected strobe edges and compare
    always @(negedge clk) begin
        if (rst_n && sec_pulse === 1'b1) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s: unexpected strobe at edge %0d, expected none", cur_req, edge_cnt);
            end else begin
                int unsigned e;
                e = exp_q.pop_front();
                if (e != edge_cnt) begin
                    fails++;
                    $display("FAIL %s: strobe at edge %0d, expected edge %0d", cur_req, edge_cnt, e);
                end
            end
        end
    end

    // Driver: one cycle of stimulus, updates model, pushes expected strobes
    task automatic step(input bit en, input bit wr, input logic [31:0] d);
        int len;
        checks++;
        if (tick_cnt !== m_pos[15:0]) begin // R2
            fails++;
            $display("FAIL R2 (%s): tick count %0d, expected %0d", cur_req, tick_cnt, m_pos);
        end
        osc_tick = en;
        cal_wr   = wr;
        cal_data = d;
        if (wr) begin
            m_n = int'(d[15:0]); m_f = int'(d[19:16]); m_fen = int'(d[20]);
            m_pos = 0; m_acc = 0;
        end else if (en) begin
            m_pos++;
            len = ((m_n == 0) ? 1 : m_n) + ((m_fen != 0 && (m_acc + m_f) >= 16) ? 1 : 0);
            if (m_pos >= len) begin
                exp_q.push_back(edge_cnt + 1);
                m_pos = 0;
                if (m_fen != 0) m_acc = (m_acc + m_f) % 16;
            end
        end
        @(negedge clk);
    endtask

    task automatic run(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, '0);
            for (int g = 1; g < gap; g++) step(1'b0, 1'b0, '0);
        end
    endtask

    task automatic drain();
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b0, '0);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d strobes missing, expected 0", cur_req, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        repeat (3) step(1'b0, 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        checks++;
        if (sec_pulse !== 1'b0 || tick_cnt !== 16'd0) begin
            fails++;
            $display("FAIL R1: pulse %0b count %0d, expected 0 0", sec_pulse, tick_cnt);
        end
        cur_req = "R1";
        run(33334, 1);
        drain();

        cur_req = "R3";
        step(1'b0, 1'b1, 32'h0000_0005);
        run(20, 1);
        run(12, 3);
        drain();

        cur_req = "R4";
        step(1'b0, 1'b1, 32'h0015_0003);
        run(60, 1);
        drain();
        step(1'b0, 1'b1, 32'h0019_0002);
        run(40, 2);
        drain();

        cur_req = "R5";
        step(1'b0, 1'b1, 32'h000F_0004);
        run(20, 1);
        drain();

        cur_req = "R8";
        step(1'b0, 1'b1, 32'hABE0_0006);
        run(14, 1);
        drain();

        cur_req = "R6";
        step(1'b0, 1'b1, 32'h0000_0006);
        run(3, 1);
        step(1'b0, 1'b1, 32'h0000_0004);
        run(9, 1);
        drain();

        cur_req = "R7";
        run(2, 1);
        step(1'b1, 1'b1, 32'h0000_0003);
        run(7, 1);
        drain();

        cur_req = "R3";
        step(1'b0, 1'b1, 32'h0018_0001);
        run(12, 1);
        drain();
        step(1'b0, 1'b1, 32'h0010_0000);
        run(4, 1);
        drain();

        finish_run();
    end
endmodule